// File: doc/BRIEF.md
# Programmable Clock Output Controller

This block generates three clock outputs for external pins. Each channel picks one of five incoming clocks and divides it by a power of two between 1 and 64. All five incoming clocks are assumed to be slower than, and sampled by, one fast reference clock `clk`. The whole block runs in that domain. A channel's divided output is built from the sampled rising edges of its selected source.

Software uses a small word-addressed register bus. The bus has an address, write data, a write strobe and a combinational read-data return. Two write-only registers handle channel enables. One register only sets enable bits and the other only clears them. A read-only status word reports which channels are on. It also reports, per channel, whether the output now runs at the programmed source and ratio.

Switching has no glitch protection. The intended sequence is to disable the channel, write its configuration, then enable it again. Every configuration write restarts that channel's divider and drops its ready flag. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `clkout_ctrl`

## Requirements
- R1: Each channel has its own configuration word, at word address 4 for channel 0, 5 for channel 1 and 6 for channel 2. Source select sits in bits [2:0] and the prescaler code in bits [6:4]. All other bits read back as zero.
- R2: Source codes 0 to 4 select `src_clk[0]` to `src_clk[4]`. These are, in order: slow clock, main clock, PLL clock, USB PLL clock divided by two, and master clock. Codes 5 to 7 select nothing: the output stays low and the channel never becomes ready.
- R3: A prescaler code p from 0 to 6 divides by N = 2^p. The output period is N source periods. For N of 2 or more the output is high for exactly half of the period. For N = 1 the output follows the sampled source.
- R4: Prescaler code 7 behaves exactly like code 6 (divide by 64).
- R5: A write to address 0 enables every channel whose bit among wdata[2:0] is 1. Zero bits leave their channel unchanged.
- R6: A write to address 1 disables every channel whose bit among wdata[2:0] is 1. Zero bits leave their channel unchanged.
- R7: Address 2 reads status. Bits [2:0] are the channel enables, bits [10:8] are the per-channel ready flags, and all other bits are 0. Writes to address 2 have no effect.
- R8: A disabled channel holds its output low and keeps its divider cleared.
- R9: A channel's ready flag drops on any write to its configuration word, even one that repeats the same value, and on disable. It sets again once N rising edges of the selected source have been counted after the restart. The ready flag reads as 0 while the channel is disabled.
- R10: When a configuration write and a counted source edge land in the same cycle, the write wins. That edge is discarded and the divider starts from zero.
- R11: After reset all channels are disabled, all configuration words are zero, all outputs are low and the status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock that samples all sources |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_clk | input | 5 | The five selectable input clocks |
| clk_out | output | 3 | The three divided clock outputs |

## Verification
Two things can fall in the same reference cycle: a configuration write to a running channel, and the consumption of a sampled rising edge of that channel's source. The bench provokes this with a channel in divide-by-1 mode. It watches that channel's output at the falling edge of `clk`, and the moment the output rises it issues a write of the unchanged configuration. That write lands on exactly the edge that would count the source rise. The collision is judged correct if ready reads 0 right after the write and returns only after one further source period.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  // configuration field widths (fixed by the register layout)
  localparam int SEL_W = 3;
  localparam int PRE_W = 3;

  // word addresses
  localparam int ADR_EN_SET = 0;
  localparam int ADR_EN_CLR = 1;
  localparam int ADR_STATUS = 2;
  localparam int ADR_CFG0   = 4;

  // bit position of the first ready flag inside the status word
  localparam int RDY_LSB = 8;

  typedef struct packed {
    logic [PRE_W-1:0] pres;
    logic [SEL_W-1:0] src;
  } chan_cfg_t;

endpackage

// File: rtl/clkout_sampler.sv
module clkout_sampler #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  output logic [NSRC-1:0] src_lvl,
  output logic [NSRC-1:0] src_rise
);

  logic [NSRC-1:0] stage_q;
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= src_in;
      prev_q  <= stage_q;
    end
  end

  assign src_lvl  = stage_q;
  assign src_rise = stage_q & ~prev_q;

  // a rise flag is only raised for one cycle per source edge
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_chk
      assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src_rise[g] |=> !src_rise[g]);
    end
  endgenerate

endmodule

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 32,
  parameter int AW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic [NCH-1:0]        ready,
  output logic [NCH-1:0]        en,
  output chan_cfg_t [NCH-1:0]   cfg,
  output logic [NCH-1:0]        restart
);

  localparam logic [AW-1:0] A_SET  = AW'(ADR_EN_SET);
  localparam logic [AW-1:0] A_CLR  = AW'(ADR_EN_CLR);
  localparam logic [AW-1:0] A_STAT = AW'(ADR_STATUS);
  localparam int PRE_LSB = 4;

  logic [NCH-1:0]      en_q;
  chan_cfg_t [NCH-1:0] cfg_q;
  logic                wr_set, wr_clr, wr_stat;

  assign wr_set  = we && (addr == A_SET);
  assign wr_clr  = we && (addr == A_CLR);
  assign wr_stat = we && (addr == A_STAT);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_dec
      assign restart[g] = we && (addr == AW'(ADR_CFG0 + g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_set) en_q <= en_q | wdata[NCH-1:0];
      if (wr_clr) en_q <= en_q & ~wdata[NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (restart[i]) begin
          cfg_q[i].src  <= wdata[SEL_W-1:0];
          cfg_q[i].pres <= wdata[PRE_LSB +: PRE_W];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_STAT) begin
      rdata[NCH-1:0]        = en_q;
      rdata[RDY_LSB +: NCH] = ready;
    end
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(ADR_CFG0 + i)) begin
        rdata[SEL_W-1:0]         = cfg_q[i].src;
        rdata[PRE_LSB +: PRE_W]  = cfg_q[i].pres;
      end
    end
  end

  assign en  = en_q;
  assign cfg = cfg_q;

  // ---------------- assertions ----------------
  assert_one_cfg_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(restart));

  assert_zero_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_set || wr_clr) && (wdata[NCH-1:0] == '0)) |=> $stable(en_q));

  assert_status_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ($stable(en_q) && $stable(cfg_q)));

  generate
    for (g = 0; g < NCH; g++) begin : g_en_chk
      assert_set_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && wdata[g]) |=> en_q[g]);
      assert_clr_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && wdata[g]) |=> !en_q[g]);
    end
  endgenerate

endmodule

// File: rtl/clkout_div.sv
module clkout_div
  import clkout_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [PRE_W-1:0] pres,
  input  logic [NSRC-1:0]  src_lvl,
  input  logic [NSRC-1:0]  src_rise,
  output logic             clk_o,
  output logic             ready
);

  // largest shift is one below the top prescaler code; the top code aliases it
  localparam int MAXSH = (1 << PRE_W) - 2;
  localparam int EW    = MAXSH + 1;   // holds the full ratio
  localparam int HW    = MAXSH;       // holds half the ratio minus one

  logic             sel_ok, lvl_sel, rise_sel;
  logic [PRE_W-1:0] shamt;
  logic [EW-1:0]    n_div;
  logic [EW-1:0]    n_half;
  logic [HW-1:0]    half_m1;

  logic [HW-1:0]    cnt_q;
  logic             tog_q;
  logic [EW-1:0]    edges_q;

  always_comb begin
    sel_ok   = 1'b0;
    lvl_sel  = 1'b0;
    rise_sel = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (src_sel == SEL_W'(k)) begin
        sel_ok   = 1'b1;
        lvl_sel  = src_lvl[k];
        rise_sel = src_rise[k];
      end
    end
  end

  always_comb begin
    shamt   = (pres > PRE_W'(MAXSH)) ? PRE_W'(MAXSH) : pres;
    n_div   = EW'(1) << shamt;
    n_half  = n_div >> 1;
    half_m1 = HW'(n_half - EW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tog_q   <= 1'b0;
      edges_q <= '0;
    end else if (!en || restart) begin
      cnt_q   <= '0;
      tog_q   <= 1'b0;
      edges_q <= '0;
    end else if (rise_sel) begin
      if (edges_q != n_div) edges_q <= edges_q + EW'(1);
      if (shamt != '0) begin
        if (cnt_q == half_m1) begin
          cnt_q <= '0;
          tog_q <= ~tog_q;
        end else begin
          cnt_q <= cnt_q + HW'(1);
        end
      end
    end
  end

  assign clk_o = en && sel_ok && ((shamt == '0) ? lvl_sel : tog_q);
  assign ready = en && sel_ok && (edges_q == n_div);

  // ---------------- assertions ----------------
  assert_off_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (edges_q == '0 && cnt_q == '0 && !tog_q));

  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ready);

  assert_ready_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(rise_sel));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && rise_sel) |=> (edges_q == '0));

  assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edges_q <= n_div);

  assert_reserved_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> (edges_q == '0));

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int NSRC = 5,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_clk,
  output logic [NCH-1:0]  clk_out
);

  logic [NSRC-1:0]     src_lvl, src_rise;
  logic [NCH-1:0]      ch_en, ch_restart, ch_ready;
  chan_cfg_t [NCH-1:0] ch_cfg;

  clkout_sampler #(.NSRC(NSRC)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_clk),
    .src_lvl  (src_lvl),
    .src_rise (src_rise)
  );

  clkout_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .ready   (ch_ready),
    .en      (ch_en),
    .cfg     (ch_cfg),
    .restart (ch_restart)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      clkout_div #(.NSRC(NSRC)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ch_en[g]),
        .restart  (ch_restart[g]),
        .src_sel  (ch_cfg[g].src),
        .pres     (ch_cfg[g].pres),
        .src_lvl  (src_lvl),
        .src_rise (src_rise),
        .clk_o    (clk_out[g]),
        .ready    (ch_ready[g])
      );
      assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_en[g] && !$past(ch_en[g])) |-> !clk_out[g]);
    end
  endgenerate

endmodule

// File: tb/sim_clkout_ctrl.sv
module sim_clkout_ctrl;

  localparam int NCH  = 3;
  localparam int NSRC = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        we;
  logic [NSRC-1:0] src = '0;
  logic [NCH-1:0]  cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int scnt [NSRC] = '{default: 0};

  always #2 clk = ~clk;

  clkout_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_we    (we),
    .bus_rdata (rdata),
    .src_clk   (src),
    .clk_out   (cout)
  );

  // source k toggles every k+2 reference cycles: period 2*(k+2)
  always @(negedge clk) begin
    for (int k = 0; k < NSRC; k++) begin
      if (scnt[k] == k + 1) begin
        scnt[k] = 0;
        src[k]  = ~src[k];
      end else begin
        scnt[k] = scnt[k] + 1;
      end
    end
  end

  function automatic int src_period(int k);
    return 2 * (k + 2);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic chk_rng(string tag, int got, int lo, int hi);
    checks++;
    if (got < lo || got > hi) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr  = 3'(a);
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
    addr  = 3'd2;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    addr = 3'(a);
    #1 d = rdata;
  endtask

  task automatic wait_ready(int ch, int limit, output int t);
    addr = 3'd2;
    t = 0;
    while (t < limit) begin
      @(negedge clk);
      t++;
      #1;
      if (rdata[8 + ch]) break;
    end
  endtask

  task automatic meas(int ch, output int hi, output int per);
    int t;
    hi = -1;
    per = -1;
    t = 0;
    while (cout[ch] !== 1'b0 && t < 2000) begin @(negedge clk); t++; end
    while (cout[ch] !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
    if (t < 4000) begin
      hi = 0;
      while (cout[ch] === 1'b1 && hi < 2000) begin @(negedge clk); hi++; end
      per = hi;
      while (cout[ch] === 1'b0 && per < 4000) begin @(negedge clk); per++; end
    end
  endtask

  task automatic count_high(int ch, int cycles, output int highs, output int rdys);
    highs = 0;
    rdys  = 0;
    addr  = 3'd2;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #1;
      if (cout[ch]) highs++;
      if (rdata[8 + ch]) rdys++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t, hi, per, highs, rdys;
    rst_n = 1'b0;
    we    = 1'b0;
    addr  = 3'd2;
    wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(2, d); chk("R11 status after reset", int'(d), 0);
    rd(4, d); chk("R11 cfg0 after reset", int'(d), 0);
    chk("R11 outputs after reset", int'(cout), 0);

    // R1 field layout and masking
    wr(5, 32'hFFFF_FFFF); rd(5, d); chk("R1 cfg1 masked", int'(d), 'h77);
    wr(6, 32'h8000_0052); rd(6, d); chk("R1 cfg2 fields", int'(d), 'h52);
    wr(4, 32'h0000_0013); rd(4, d); chk("R1 cfg0 fields", int'(d), 'h13);

    // R7 status is read-only
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R7 status write ignored", int'(d), 0);
    rd(5, d); chk("R7 cfg1 untouched by status write", int'(d), 'h77);

    // R5 / R6 set and clear semantics
    wr(0, 32'h5); rd(2, d); chk("R5 set ch0 ch2", int'(d[2:0]), 5);
    wr(0, 32'h0); rd(2, d); chk("R5 zero set no effect", int'(d[2:0]), 5);
    wr(1, 32'h0); rd(2, d); chk("R6 zero clear no effect", int'(d[2:0]), 5);
    wr(1, 32'h1); rd(2, d); chk("R6 clear ch0", int'(d[2:0]), 4);
    wr(1, 32'h4); rd(2, d); chk("R6 clear ch2", int'(d[2:0]), 0);
    chk("R7 upper status bits zero", int'(d[31:11]), 0);

    // R8 disabled channel holds output low
    wr(4, 32'h0);
    count_high(0, 60, highs, rdys);
    chk("R8 disabled output low", highs, 0);
    chk("R9 disabled ready low", rdys, 0);
    wr(0, 32'h1);
    count_high(0, 60, highs, rdys);
    chk_rng("R3 enabled divide-by-1 toggles", highs, 20, 40);
    wr(1, 32'h1);
    rd(2, d); chk("R9 ready drops on disable", int'(d[8]), 0);
    count_high(0, 60, highs, rdys);
    chk("R8 output low after disable", highs, 0);

    // R2 reserved source codes
    for (int c = 5; c < 8; c++) begin
      wr(6, 32'(c));
      wr(0, 32'h4);
      count_high(2, 100, highs, rdys);
      chk("R2 reserved source output", highs, 0);
      chk("R2 reserved source ready", rdys, 0);
      wr(1, 32'h4);
    end

    // R10 write collides with a counted source edge
    wr(5, 32'h0);
    wr(0, 32'h2);
    wait_ready(1, 40, t);
    chk_rng("R9 ready before collision", t, 0, 8);
    t = 0;
    while (!(cout[1] === 1'b1) && t < 100) begin @(negedge clk); t++; end
    while (!(cout[1] === 1'b0) && t < 100) begin @(negedge clk); t++; end
    while (!(cout[1] === 1'b1) && t < 100) begin @(negedge clk); t++; end
    addr  = 3'd5;
    wdata = 32'h0;
    we    = 1'b1;
    @(negedge clk);
    we   = 1'b0;
    addr = 3'd2;
    #1 chk("R10 write beats coincident edge", int'(rdata[9]), 0);
    wait_ready(1, 40, t);
    chk_rng("R9 ready returns after one period", t, 2, src_period(0) + 4);
    wr(1, 32'h2);

    // R2 R3 R4 R9 sweep over every channel, source and prescaler code
    for (int ch = 0; ch < NCH; ch++) begin
      for (int s = 0; s < NSRC; s++) begin
        for (int p = 0; p < 8; p++) begin
          int n, pp;
          string tg;
          n  = (p == 7) ? 64 : (1 << p);
          pp = src_period(s);
          tg = (p == 7) ? "R4" : "R3";
          wr(1, 32'(1 << ch));
          wr(4 + ch, 32'((p << 4) | s));
          wr(0, 32'(1 << ch));
          wait_ready(ch, n * pp + 20, t);
          chk_rng($sformatf("R9 ready latency ch%0d src%0d code%0d", ch, s, p),
                  t, (n - 1) * pp, n * pp + 4);
          meas(ch, hi, per);
          chk($sformatf("%s period ch%0d src%0d code%0d", tg, ch, s, p), per, n * pp);
          chk($sformatf("%s high time ch%0d src%0d code%0d", tg, ch, s, p), hi,
              (n == 1) ? pp / 2 : n * pp / 2);
        end
      end
      wr(1, 32'(1 << ch));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule